// File: doc/BRIEF.md
# Event and Gated-Time Pulse Accumulator

This block counts activity on one external input with an 8-bit accumulator. In event mode the accumulator steps once for each selected edge on the input. In gated mode it measures how long the input stays at its active level: the accumulator steps once every 64 system clocks while the input is active and holds while it is not. One polarity bit serves both modes. In event mode it picks the counted edge, and in gated mode it picks the active level.

Software sets up the block and reads it through a small write port with three addresses: control, counter and flags. The current values appear on dedicated outputs. An edge flag and an overflow flag latch the block's events. Software clears each flag by writing a one to it. Each flag raises an interrupt request when its local enable is set. The counter has no reset, so a measurement survives a reset of the block.

Top module: `pulse_accum`

## Requirements
- R1: A reset sets all control bits to 0 (disabled, event mode, polarity 0, both interrupt enables off) and clears both flags. The counter keeps its value through reset.
- R2: A write with `bus_we`=1 decodes `bus_addr` as follows. Address 0 loads control: bit0 enable, bit1 mode (0 event, 1 gated), bit2 polarity, bit3 edge interrupt enable, bit4 overflow interrupt enable. Address 1 loads the counter. Address 2 is the flag clear (bit0 edge flag, bit1 overflow flag).
- R3: While enable is 0, the counter changes only through a bus write, and neither flag is set by hardware.
- R4: The input passes through two synchronizing flops. A level on `pin_in` that is first sampled at clock edge n takes effect on the counter and flags at edge n+2.
- R5: In event mode, polarity 0 counts falling edges and polarity 1 counts rising edges. Each counted edge also sets the edge flag.
- R6: In gated mode, a free-running divide-by-64 prescaler starts from zero at reset and ticks on the 64th, 128th, … clock edge after reset. On each tick the counter advances if the gate is active. Polarity 0 makes the input's high level active, and polarity 1 makes its low level active. The counter holds while the gate is inactive.
- R7: In gated mode, the edge flag is set on the edge that ends the active level. This is the falling edge for polarity 0 and the rising edge for polarity 1.
- R8: When an increment takes the counter from 0xFF to 0x00, the overflow flag is set.
- R9: `irq_edge` is high exactly when the edge flag and its enable (control bit3) are both set. `irq_ovf` is high exactly when the overflow flag and its enable (control bit4) are both set.
- R10: Writing 1 to a flag bit at address 2 clears that flag. Writing 0 leaves it unchanged. A hardware set in the same cycle wins over the clear.
- R11: A bus write to the counter takes priority over a same-cycle increment and suppresses its overflow. Without a write, the counter moves by at most one per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 1 | Asynchronous accumulator input |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Write address: 0 control, 1 counter, 2 flag clear |
| bus_wdata | input | 8 | Write data |
| cnt_q | output | 8 | Accumulator value |
| ctrl_q | output | 5 | Control register value |
| flag_edge | output | 1 | Input-edge flag |
| flag_ovf | output | 1 | Overflow flag |
| irq_edge | output | 1 | Edge interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |

## Verification
The bench targets the following corner cases.
- **Input latency.** The bench checks the exact cycle in which a pin change reaches the counter. A design with one synchronizer stage too many or too few would count a cycle early or late.
- **Polarity.** The bench runs both polarities in both modes. A design that swapped the edge sense, or that raised the gated-mode edge flag on the leading edge, would count the wrong transitions.
- **Wrap and overflow.** The bench forces the counter through the wrap from 0xFF. A design that missed the overflow flag, or that reset the counter during a reset, would hold the wrong value afterwards.
- **Write against increment.** The bench keeps counter writes going while prescaler ticks arrive. A design that let the increment win would drift away from the written value.
- **Clear against set.** The bench keeps a flag clear active while edges arrive. A design that let the clear win would lose the event.

// File: rtl/pacc_pkg.sv
package pacc_pkg;

    localparam int CTRL_W = 5;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_CNT  = 2'd1;
    localparam logic [1:0] ADDR_FLAG = 2'd2;

    localparam int FLAG_EDGE_BIT = 0;
    localparam int FLAG_OVF_BIT  = 1;

    typedef enum logic {
        MODE_EVENT = 1'b0,
        MODE_GATED = 1'b1
    } acc_mode_e;

    typedef struct packed {
        logic      ie_ovf;
        logic      ie_edge;
        logic      pol;
        acc_mode_e mode;
        logic      en;
    } ctrl_t;

    // Edge of interest for one polarity setting. In both modes it is the same
    // transition: counted edge in event mode, trailing edge in gated mode.
    function automatic logic edge_pick(input logic pol, input logic rise, input logic fall);
        return pol ? rise : fall;
    endfunction

    // Gate is active when the synchronized level differs from the polarity bit.
    function automatic logic gate_level_ok(input logic pol, input logic lvl);
        return lvl ^ pol;
    endfunction

endpackage

// File: rtl/pacc_sync.sv
module pacc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic lvl,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-1:0], pin};
    end

    assign lvl  = sh[STAGES-1];
    assign rise = sh[STAGES-1] & ~sh[STAGES];
    assign fall = ~sh[STAGES-1] & sh[STAGES];
endmodule

// File: rtl/pacc_prescale.sv
module pacc_prescale #(
    parameter int DIV = 64
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] pc;

    assign tick = (pc == LAST);

    always_ff @(posedge clk) begin
        if (rst)       pc <= '0;
        else if (tick) pc <= '0;
        else           pc <= pc + PW'(1);
    end
endmodule

// File: rtl/pacc_counter.sv
module pacc_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    // Deliberately no reset: the value is kept across reset.
    always_ff @(posedge clk) begin
        if (wr)       cnt <= wdata;
        else if (inc) cnt <= cnt + W'(1);
    end

    assign wrap = inc && !wr && (&cnt);
endmodule

// File: rtl/pulse_accum.sv
module pulse_accum
    import pacc_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int DIV         = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                pin_in,
    input  logic                bus_we,
    input  logic [1:0]          bus_addr,
    input  logic [CNT_W-1:0]    bus_wdata,
    output logic [CNT_W-1:0]    cnt_q,
    output logic [CTRL_W-1:0]   ctrl_q,
    output logic                flag_edge,
    output logic                flag_ovf,
    output logic                irq_edge,
    output logic                irq_ovf
);
    ctrl_t ctrl_r;
    logic  lvl, rise, fall, tick;
    logic  wr_ctrl, wr_cnt, wr_flag;
    logic  edge_hit, gate_on, inc, wrap;

    assign wr_ctrl = bus_we && (bus_addr == ADDR_CTRL);
    assign wr_cnt  = bus_we && (bus_addr == ADDR_CNT);
    assign wr_flag = bus_we && (bus_addr == ADDR_FLAG);

    pacc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .pin(pin_in), .lvl(lvl), .rise(rise), .fall(fall)
    );

    pacc_prescale #(.DIV(DIV)) u_pre (
        .clk(clk), .rst(rst), .tick(tick)
    );

    assign edge_hit = ctrl_r.en && edge_pick(ctrl_r.pol, rise, fall);
    assign gate_on  = ctrl_r.en && (ctrl_r.mode == MODE_GATED) && gate_level_ok(ctrl_r.pol, lvl);

    always_comb begin
        if (ctrl_r.mode == MODE_EVENT) inc = edge_hit;
        else                           inc = gate_on && tick;
    end

    pacc_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .wr(wr_cnt), .wdata(bus_wdata), .inc(inc), .cnt(cnt_q), .wrap(wrap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_r <= '0;
        end else if (wr_ctrl) begin
            ctrl_r <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_edge <= 1'b0;
            flag_ovf  <= 1'b0;
        end else begin
            flag_edge <= (flag_edge && !(wr_flag && bus_wdata[FLAG_EDGE_BIT])) || edge_hit;
            flag_ovf  <= (flag_ovf  && !(wr_flag && bus_wdata[FLAG_OVF_BIT]))  || wrap;
        end
    end

    assign ctrl_q   = ctrl_r;
    assign irq_edge = flag_edge && ctrl_r.ie_edge;
    assign irq_ovf  = flag_ovf  && ctrl_r.ie_ovf;
endmodule

// File: rtl/pacc_checker.sv
module pacc_checker #(
    parameter int CNT_W  = 8,
    parameter int CTRL_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_we,
    input logic [1:0]        bus_addr,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [CTRL_W-1:0] ctrl_q,
    input logic              flag_edge,
    input logic              flag_ovf,
    input logic              gate_on
);
    logic cnt_wr;
    assign cnt_wr = bus_we && (bus_addr == 2'd1);

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (ctrl_q == '0 && !flag_edge && !flag_ovf));

    assert_disabled_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q[0] && !cnt_wr) |=> $stable(cnt_q));

    assert_gate_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q[0] && ctrl_q[1] && !gate_on && !cnt_wr) |=> $stable(cnt_q));

    assert_wrap_sets_ovf_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_ovf) |-> ($past(cnt_q) == {CNT_W{1'b1}} && cnt_q == '0));

    assert_single_step_R11: assert property (@(posedge clk) disable iff (rst)
        !cnt_wr |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CNT_W'(1)));
endmodule

bind pulse_accum pacc_checker #(.CNT_W(CNT_W), .CTRL_W(pacc_pkg::CTRL_W)) u_chk (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr), .cnt_q(cnt_q),
    .ctrl_q(ctrl_q), .flag_edge(flag_edge), .flag_ovf(flag_ovf), .gate_on(gate_on)
);

// File: tb/pulse_accum_tb.sv
module pulse_accum_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pin_in = 1'b0;
    logic       bus_we = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] cnt_q;
    logic [4:0] ctrl_q;
    logic       flag_edge, flag_ovf, irq_edge, irq_ovf;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    string cur_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    pulse_accum dut_i (
        .clk(clk), .rst(rst), .pin_in(pin_in), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .cnt_q(cnt_q), .ctrl_q(ctrl_q), .flag_edge(flag_edge),
        .flag_ovf(flag_ovf), .irq_edge(irq_edge), .irq_ovf(irq_ovf)
    );

    // Behavioural reference model
    int m_cnt = 0, m_ctrl = 0, m_fe = 0, m_fo = 0, m_pc = 0;
    bit m_known = 0;
    int hist[$] = '{0, 0, 0};   // hist[0] newest sample

    always @(posedge clk) begin
        if (rst) begin
            m_ctrl = 0; m_fe = 0; m_fo = 0; m_pc = 0;
            hist = '{0, 0, 0};
        end else begin
            int lvl, prv, en, mode, pol, edge_ev, tick, inc, wr_cnt, clr;
            lvl = hist[1]; prv = hist[2];
            en = m_ctrl & 1; mode = (m_ctrl >> 1) & 1; pol = (m_ctrl >> 2) & 1;
            edge_ev = en && (pol ? (lvl && !prv) : (!lvl && prv));
            tick = (m_pc == 63);
            inc = mode ? (en && tick && (lvl != pol)) : edge_ev;
            wr_cnt = bus_we && bus_addr == 2'd1;
            clr = (bus_we && bus_addr == 2'd2) ? int'(bus_wdata) : 0;
            m_fe = (m_fe && !(clr & 1)) || edge_ev;
            m_fo = (m_fo && !(clr & 2)) ? 1 : 0;
            if (wr_cnt) begin
                m_cnt = int'(bus_wdata); m_known = 1;
            end else if (inc) begin
                if (m_cnt == 255) m_fo = 1;
                m_cnt = (m_cnt + 1) % 256;
            end
            if (bus_we && bus_addr == 2'd0) m_ctrl = int'(bus_wdata) & 31;
            void'(hist.pop_back());
            hist.push_front(int'(pin_in));
            m_pc = (m_pc + 1) % 64;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        if (m_known) check(cur_req, "cnt_q", int'(cnt_q), m_cnt);
        check(cur_req, "ctrl_q", int'(ctrl_q), m_ctrl);
        check(cur_req, "flag_edge", int'(flag_edge), m_fe);
        check(cur_req, "flag_ovf", int'(flag_ovf), m_fo);
        check(cur_req, "irq_edge R9", int'(irq_edge), int'(m_fe && ((m_ctrl >> 3) & 1)));
        check(cur_req, "irq_ovf R9", int'(irq_ovf), int'(m_fo && ((m_ctrl >> 4) & 1)));
    endtask

    task automatic step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_we = 1'b0;
    endtask

    task automatic pulses(input int n, input int hi, input int lo);
        for (int i = 0; i < n; i++) begin
            pin_in = 1'b1; repeat (hi) step();
            pin_in = 1'b0; repeat (lo) step();
        end
    endtask

    initial begin
        int c0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cur_req = "R1"; step();
        check("R1", "ctrl after reset", int'(ctrl_q), 0);
        check("R1", "flags after reset", int'({flag_ovf, flag_edge}), 0);

        cur_req = "R2"; wr(2'd1, 8'h10);
        check("R2", "counter write", int'(cnt_q), 16);

        cur_req = "R3"; pulses(3, 4, 4);
        check("R3", "disabled counter", int'(cnt_q), 16);
        check("R3", "disabled flags", int'({flag_ovf, flag_edge}), 0);

        cur_req = "R5"; wr(2'd0, 8'h05); pulses(3, 4, 4);
        check("R5", "rising count", int'(cnt_q), 16 + 3);

        cur_req = "R4"; repeat (4) step();
        c0 = int'(cnt_q); pin_in = 1'b1;
        step(); step();
        check("R4", "no count before sync", int'(cnt_q), c0);
        step();
        check("R4", "count at third edge", int'(cnt_q), c0 + 1);
        repeat (3) step(); pin_in = 1'b0; repeat (4) step();

        cur_req = "R10"; wr(2'd2, 8'h01);
        check("R10", "edge flag cleared", int'(flag_edge), 0);

        cur_req = "R5"; wr(2'd0, 8'h01); c0 = int'(cnt_q); pulses(2, 5, 5);
        check("R5", "falling count", int'(cnt_q), c0 + 2);

        cur_req = "R8"; wr(2'd0, 8'h15); wr(2'd1, 8'hFE); pulses(2, 4, 4);
        check("R8", "wrapped counter", int'(cnt_q), 0);
        check("R8", "overflow flag", int'(flag_ovf), 1);
        check("R9", "overflow irq", int'(irq_ovf), 1);
        cur_req = "R10"; wr(2'd2, 8'h02);
        check("R10", "overflow cleared", int'(flag_ovf), 0);

        cur_req = "R1"; wr(2'd1, 8'h5A);
        rst = 1'b1; repeat (3) step(); rst = 1'b0; step();
        check("R1", "counter kept over reset", int'(cnt_q), 90);

        cur_req = "R6"; wr(2'd1, 8'h00); wr(2'd0, 8'h03);
        pin_in = 1'b1; repeat (300) step();
        check("R6", "gated high counted", int'(cnt_q >= 8'd4), 1);
        pin_in = 1'b0; repeat (4) step();
        cur_req = "R7";
        check("R7", "trailing edge flag pol0", int'(flag_edge), 1);
        cur_req = "R6"; c0 = int'(cnt_q); repeat (200) step();
        check("R6", "gate inactive hold", int'(cnt_q), c0);

        wr(2'd2, 8'h01); wr(2'd0, 8'h07); repeat (200) step();
        check("R6", "active-low counted", int'(cnt_q > 8'(c0)), 1);
        check("R7", "no flag at leading edge", int'(flag_edge), 0);
        pin_in = 1'b1; repeat (4) step();
        cur_req = "R7";
        check("R7", "trailing edge flag pol1", int'(flag_edge), 1);

        cur_req = "R11"; wr(2'd0, 8'h03);
        bus_we = 1'b1; bus_addr = 2'd1; bus_wdata = 8'h40;
        repeat (140) step();
        bus_we = 1'b0;
        check("R11", "write beats increment", int'(cnt_q), 64);
        pin_in = 1'b0; repeat (4) step();

        cur_req = "R10"; wr(2'd0, 8'h0D);
        bus_we = 1'b1; bus_addr = 2'd2; bus_wdata = 8'h01;
        pulses(4, 3, 5);
        bus_we = 1'b0;

        cur_req = "R9"; pulses(1, 4, 2);
        check("R9", "edge irq", int'(irq_edge), 1);
        wr(2'd0, 8'h05);
        check("R9", "edge irq masked", int'(irq_edge), 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule